// File: doc/BRIEF.md
# Prescaled SCL Waveform Generator

This block derives the SCL clock of a two-wire bus master from the system clock. A 32-bit configuration word carries a divider for the low phase, a divider for the high phase and a power-of-two prescaler exponent. Each phase lasts the phase divider shifted left by the exponent, plus a fixed number of extra system clocks that is set per build. Low and high dividers are independent, so the duty cycle need not be 50 %.

The transfer sequencer raises `run` to start clocking and drops it to return the line to idle. On every phase boundary the block pulses `tick` for one cycle, which the sequencer uses to schedule data changes. `hold` lets the sequencer stretch SCL: the phase counter freezes and the requested level is low. A configuration write while idle is used at once. A write while clocking waits for the next phase boundary, so no phase is cut short or measured against a mix of two settings.

Top module: `scl_wavegen`

## Requirements
- R1: After reset, with `run` low, `scl_level` is 1 and `tick` is 0, and the stored configuration is all zero, so both phases last OFFSET cycles.
- R2: With `run` high and `hold` low, the low phase shows `scl_level` = 0 for exactly lo_div·2^exp + OFFSET cycles. It begins in the first cycle `run` is high.
- R3: The high phase that follows shows `scl_level` = 1 for exactly hi_div·2^exp + OFFSET cycles, and the phases then keep alternating.
- R4: `tick` is 1 in the last cycle of each phase and in no other cycle. The level changes in the next cycle.
- R5: Field positions in `cfg_wdata`: lo_div in bits 7:0, hi_div in bits 15:8, exp in bits 18:16. Bits 31:19 have no effect.
- R6: An exp field greater than MAX_EXP is used as MAX_EXP.
- R7: A divider of zero gives a phase of OFFSET cycles, never zero.
- R8: While `run` and `hold` are both high, `scl_level` is 0, `tick` is 0 and the phase counter does not advance. After `hold` falls the phase completes its remaining cycles.
- R9: While `run` is low, `scl_level` is 1 and `tick` is 0. The next rise of `run` starts a fresh, full-length low phase.
- R10: A write (`cfg_we` high) while `run` is low takes effect from the next cycle. A write while `run` is high takes effect at the next phase boundary, and the current phase keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word (lo_div, hi_div, exp fields) |
| run | input | 1 | Clocking enable from the sequencer |
| hold | input | 1 | Stretch request: freeze the count and force the low level |
| tick | output | 1 | Single-cycle pulse in the last cycle of each phase |
| scl_level | output | 1 | Requested SCL level (1 = released high) |

## Verification
The bench builds the block with OFFSET = 3 and MAX_EXP = 5. With a 3-bit exponent field, MAX_EXP = 5 lets written values 6 and 7 occur, so the clamp can be exercised. The smaller offset also makes zero-divider phases distinct from the default build. The configuration words mix asymmetric dividers, exponents from 0 to 7, zero dividers and junk in the upper bits. The directed cases cover stretching in both phases, a write deferred to a phase boundary, and an abort followed by a restart.

// File: rtl/scl_wg_pkg.sv
package scl_wg_pkg;

  // Field placement inside the configuration word.
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 8;
  localparam int EXP_LSB = 16;
  localparam int DIV_W   = 8;
  localparam int EXP_W   = 3;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } wave_cfg_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Counter width that holds the longest phase for a given build.
  function automatic int cnt_width(input int offset, input int max_exp);
    int longest;
    longest = (((1 << DIV_W) - 1) << max_exp) + offset;
    return $clog2(longest + 1);
  endfunction

endpackage

// File: rtl/scl_wg_rst_sync.sv
module scl_wg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/scl_wg_cfg.sv
module scl_wg_cfg
  import scl_wg_pkg::*;
#(
  parameter int MAX_EXP = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        apply_ok,
  output wave_cfg_t   cfg
);

  wave_cfg_t        dec;
  logic [EXP_W-1:0] exp_raw;
  logic             unused_hi_bits;

  wave_cfg_t cur_q, cur_d;
  wave_cfg_t pend_q, pend_d;
  logic      pend_v_q, pend_v_d;
  logic      cur_en, pend_en;

  // Field decode with exponent clamp.
  always_comb begin
    exp_raw    = wdata[EXP_LSB +: EXP_W];
    dec.lo_div = wdata[LO_LSB +: DIV_W];
    dec.hi_div = wdata[HI_LSB +: DIV_W];
    if (int'(exp_raw) > MAX_EXP) dec.expo = EXP_W'(MAX_EXP);
    else                         dec.expo = exp_raw;
  end

  assign unused_hi_bits = ^wdata[31:EXP_LSB+EXP_W];

  // Next state: apply now when allowed, otherwise park in the pending slot.
  always_comb begin
    cur_d    = cur_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    cur_en   = 1'b0;
    pend_en  = 1'b0;
    if (we && apply_ok) begin
      cur_d    = dec;
      pend_v_d = 1'b0;
      cur_en   = 1'b1;
      pend_en  = 1'b1;
    end else if (we) begin
      pend_d   = dec;
      pend_v_d = 1'b1;
      pend_en  = 1'b1;
    end else if (pend_v_q && apply_ok) begin
      cur_d    = pend_q;
      pend_v_d = 1'b0;
      cur_en   = 1'b1;
      pend_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else if (pend_en) begin
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign cfg = cur_q;

endmodule

// File: rtl/scl_wg_phase.sv
module scl_wg_phase
  import scl_wg_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 7,
  localparam int CNT_W  = cnt_width(OFFSET, MAX_EXP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  wave_cfg_t        cfg,
  output logic             tick,
  output logic             phase_hi,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_sel;
  logic             last;
  logic             step_en;

  // Phase length from the divider of the current phase.
  always_comb begin
    div_sel = (phase_q == PH_HIGH) ? cfg.hi_div : cfg.lo_div;
    len     = (CNT_W'(div_sel) << cfg.expo) + CNT_W'(OFFSET);
    last    = (cnt_q == len - CNT_W'(1));
  end

  assign tick    = run && !hold && last;
  assign step_en = !run || !hold;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = PH_LOW;
    end else if (last) begin
      cnt_d   = '0;
      phase_d = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_d   = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
    end else if (step_en) begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_hi = (phase_q == PH_HIGH);
  assign cnt      = cnt_q;

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wg_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        run,
  input  logic        hold,
  output logic        tick,
  output logic        scl_level
);

  localparam int CNT_W = cnt_width(OFFSET, MAX_EXP);

  logic             rst_q_n;
  wave_cfg_t        cfg;
  logic             phase_hi;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phase_len;
  logic             apply_ok;

  scl_wg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign apply_ok = !run || tick;

  scl_wg_cfg #(.MAX_EXP(MAX_EXP)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .apply_ok (apply_ok),
    .cfg      (cfg)
  );

  scl_wg_phase #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) u_phase (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .run      (run),
    .hold     (hold),
    .cfg      (cfg),
    .tick     (tick),
    .phase_hi (phase_hi),
    .cnt      (cnt),
    .len      (phase_len)
  );

  always_comb begin
    if (!run)      scl_level = 1'b1;
    else if (hold) scl_level = 1'b0;
    else           scl_level = phase_hi;
  end

endmodule

// File: rtl/scl_wavegen_chk.sv
module scl_wavegen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             hold,
  input logic             tick,
  input logic             scl_level,
  input logic             phase_hi,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len
);

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

  // R4
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (run && !hold));

  // R4
  toggle_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phase_hi != $past(phase_hi)));

  // R8
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |-> !scl_level);

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> (cnt == $past(cnt)));

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (scl_level && !tick));

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !phase_hi));

endmodule

bind scl_wavegen scl_wavegen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .run       (run),
  .hold      (hold),
  .tick      (tick),
  .scl_level (scl_level),
  .phase_hi  (phase_hi),
  .cnt       (cnt),
  .len       (phase_len)
);

// File: tb/scl_wavegen_tb.sv
module scl_wavegen_tb;

  localparam int OFFSET  = 3;
  localparam int MAX_EXP = 5;
  localparam int LIMIT   = 5000;
  localparam int WD      = 150000;
  localparam int NVEC    = 8;

  typedef struct packed {
    logic [31:0] word;
    logic [15:0] lo_len;
    logic [15:0] hi_len;
  } vec_t;

  // Expected lengths: div * 2^min(exp,5) + 3
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 16'd3,  16'd3 },  // R7 zero dividers
    '{32'h0000_0502, 16'd5,  16'd8 },  // R2 R3 asymmetric, exp 0
    '{32'h0002_0103, 16'd15, 16'd7 },  // R2 R3 exp 2
    '{32'h0005_0201, 16'd35, 16'd67},  // R3 exp at maximum
    '{32'h0007_0101, 16'd35, 16'd35},  // R6 exp 7 clamped to 5
    '{32'h0006_0100, 16'd3,  16'd35},  // R6 R7 exp 6 clamped, lo zero
    '{32'hFFF8_0403, 16'd6,  16'd7 },  // R5 upper bits ignored
    '{32'h0001_0010, 16'd35, 16'd3 }   // R5 R7 hi zero
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        run;
  logic        hold;
  logic        tick;
  logic        scl_level;

  int compared = 0;
  int mismatched = 0;

  scl_wavegen #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .run       (run),
    .hold      (hold),
    .tick      (tick),
    .scl_level (scl_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk);
    run = 1'b1;
    #1;
  endtask

  task automatic stop_run();
    run = 1'b0;
    @(negedge clk);
    #1;
  endtask

  // Count samples while scl_level equals lvl; tpos = sample index of tick.
  task automatic count_phase(input logic lvl, output int n, output int tpos);
    n = 0;
    tpos = -1;
    while (scl_level === lvl && n < LIMIT) begin
      n++;
      if (tick) tpos = n;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n, tp, n2, tp2;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    run = 1'b0;
    hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1 reset state
    check("R1 idle level", int'(scl_level), 1);
    check("R1 idle tick", int'(tick), 0);
    start_run();
    count_phase(1'b0, n, tp);
    check("R1 reset low len", n, OFFSET);
    count_phase(1'b1, n, tp);
    check("R1 reset high len", n, OFFSET);
    stop_run();

    // Table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      write_cfg(VECS[i].word);
      start_run();
      count_phase(1'b0, n, tp);
      check($sformatf("R2 low len vec%0d", i), n, int'(VECS[i].lo_len));
      check($sformatf("R4 low tick vec%0d", i), tp, n);
      count_phase(1'b1, n2, tp2);
      check($sformatf("R3 high len vec%0d", i), n2, int'(VECS[i].hi_len));
      check($sformatf("R4 high tick vec%0d", i), tp2, n2);
      stop_run();
    end

    // R8 hold in low phase: lo=4 exp0 -> 7 cycles
    write_cfg(32'h0000_0204);
    start_run();
    @(negedge clk); #1;
    @(negedge clk); #1;
    hold = 1'b1;
    #1;
    for (int k = 0; k < 5; k++) begin
      check("R8 hold level", int'(scl_level), 0);
      check("R8 hold tick", int'(tick), 0);
      @(negedge clk); #1;
    end
    hold = 1'b0;
    #1;
    count_phase(1'b0, n, tp);
    check("R8 remaining low", n, 5);
    @(negedge clk); #1;
    hold = 1'b1;
    #1;
    check("R8 hold in high", int'(scl_level), 0);
    @(negedge clk); #1;
    hold = 1'b0;
    #1;
    check("R8 release high", int'(scl_level), 1);
    stop_run();
    check("R9 idle after stop", int'(scl_level), 1);

    // R10 write during low phase deferred to boundary
    write_cfg(32'h0000_0202);
    start_run();
    cfg_we = 1'b1;
    cfg_wdata = 32'h0000_0606;
    @(negedge clk); #1;
    cfg_we = 1'b0;
    count_phase(1'b0, n, tp);
    check("R10 current low kept", n + 1, 5);
    count_phase(1'b1, n, tp);
    check("R10 new high", n, 9);
    count_phase(1'b0, n, tp);
    check("R10 new low", n, 9);
    stop_run();

    // R9 abort mid-high then fresh restart
    write_cfg(32'h0000_0202);
    start_run();
    count_phase(1'b0, n, tp);
    @(negedge clk); #1;
    run = 1'b0;
    #1;
    check("R9 abort level", int'(scl_level), 1);
    check("R9 abort tick", int'(tick), 0);
    hold = 1'b1;
    #1;
    check("R9 hold ignored idle", int'(scl_level), 1);
    @(negedge clk);
    hold = 1'b0;
    start_run();
    count_phase(1'b0, n, tp);
    check("R9 fresh low", n, 5);
    stop_run();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule